// File: doc/BRIEF.md
# Error-Bounds Monitor with Interrupt Combiner

This block watches a stream of signed 8-bit frequency-error samples produced by an upstream error generator. Each qualified sample is compared against two programmable limits, and a sample lying outside that window marks a bounds event. The block also collects three single-cycle event pulses: accumulation finished, average-error valid, and the block's own disable acknowledge. Each of the four sources latches into a pending bit. A pending bit is routed to a CPU interrupt line through its own enable.

The bounds event has a second consumer, a voltage-processor line with an enable separate from the CPU one. In hardware voltage control, software turns on the voltage-processor line and may also keep the CPU bounds interrupt on to watch activity. In software control, only the CPU line is used. When software clears the module enable, the block wipes every pending bit in the following cycle. One cycle after that it raises the disable acknowledge, which tells software that the block can be reprogrammed.

A small register port gives software access to the control, limit, enable, pending and status words. Three validity flags from the upstream datapath are reported in the status word.

Top module: `err_bound_irq`

## Requirements
- R1: After reset, every pending bit and enable bit is 0. The module enable is 0. The limit word reads 0x7F80 (maximum +127, minimum -128), and both interrupt outputs are low.
- R2: A sample with sampleValid high while the module is enabled sets pending bit 3 at the next clock edge when the sample is strictly above the maximum or strictly below the minimum. All values are compared as signed two's complement. A sample equal to either limit does not set it.
- R3: A sample with sampleValid low has no effect on pending bit 3. While the module enable is 0, samples, accumDone and avgValid change no pending bit.
- R4: While the module is enabled, accumDone sets pending bit 0 and avgValid sets pending bit 1. Each is set at the next edge, whatever the interrupt enables hold.
- R5: Writing the pending word (address 3) clears each pending bit whose written bit is 1. Pending bits written with 0 are unchanged.
- R6: When an event sets a pending bit in the same cycle that a write-1 clears it, the bit ends up set.
- R7: cpuIrq is high exactly when some pending bit i (i = 0..3) has its enable bit i set in the enable word (address 2).
- R8: vpIrq is high exactly when pending bit 3 is set and enable bit 4 is set. It is independent of enable bit 3.
- R9: When the module enable (address 0, bit 0) is written from 1 to 0, all pending bits are 0 one clock later. Pending bit 2 (disable acknowledge) is set at the clock after that.
- R10: The status word (address 4) reads avgErrOk in bit 3, minMaxOk in bit 2 and errGenOk in bit 1. All other bits are 0.
- R11: The limit word (address 1) holds the maximum limit in bits [15:8] and the minimum limit in bits [7:0]. It reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address (0 ctrl, 1 limits, 2 enables, 3 pending, 4 status) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr, combinational |
| sampleValid | input | 1 | Qualifies sampleErr |
| sampleErr | input | 8 | Signed frequency-error sample |
| accumDone | input | 1 | Accumulation-finished event pulse |
| avgValid | input | 1 | Average-valid event pulse |
| avgErrOk | input | 1 | Average-error validity flag |
| minMaxOk | input | 1 | Min/max/average validity flag |
| errGenOk | input | 1 | Error-generator validity flag |
| cpuIrq | output | 1 | Combined CPU interrupt |
| vpIrq | output | 1 | Bounds interrupt to the voltage processor |

## Verification
Two situations are hard to reach from the ports. The first is an event that arrives on the exact edge where software writes 1 to clear the same pending bit. The bench reaches it by driving the event pulse and the clearing write in the same half-cycle. The second is the two-step disable sequence. To observe it, the bench first fills several pending bits, clears the module enable, and then reads the pending word at three consecutive low clock phases: before the wipe, after the wipe, and after the acknowledge. A table of signed limit/sample pairs covers the boundary cases, with samples equal to a limit, one step past it, and the full-scale extremes.

// File: rtl/err_bound_pkg.sv
package err_bound_pkg;

  localparam int unsigned NUM_SRC    = 4;
  localparam int unsigned SRC_ACC    = 0;
  localparam int unsigned SRC_VALID  = 1;
  localparam int unsigned SRC_DISACK = 2;
  localparam int unsigned SRC_BOUNDS = 3;
  localparam int unsigned VP_EN_BIT  = NUM_SRC;

  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_LIMIT  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_IEN    = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_PEND   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;  // wipe every pending bit
    logic setAck;    // raise disable acknowledge
    logic evtGate;   // events and samples are accepted
  } ctlStrobe_t;

endpackage

// File: rtl/err_bound_cmp.sv
module err_bound_cmp #(
  parameter int unsigned ERR_W = 8
) (
  input  logic             valid,
  input  logic             gate,
  input  logic [ERR_W-1:0] sample,
  input  logic [ERR_W-1:0] maxLim,
  input  logic [ERR_W-1:0] minLim,
  output logic             hit
);
  logic aboveMax;
  logic belowMin;

  always_comb begin
    aboveMax = $signed(sample) > $signed(maxLim);
    belowMin = $signed(sample) < $signed(minLim);
    hit      = valid && gate && (aboveMax || belowMin);
  end
endmodule

// File: rtl/err_bound_ctl.sv
module err_bound_ctl
  import err_bound_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modEn,
  output ctlStrobe_t strb
);
  logic enPrev;
  logic ackQ;
  logic enFall;

  assign enFall = enPrev && !modEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev <= 1'b0;
      ackQ   <= 1'b0;
    end else begin
      enPrev <= modEn;
      ackQ   <= enFall;
    end
  end

  always_comb begin
    strb.clearAll = enFall;
    strb.setAck   = ackQ;
    strb.evtGate  = modEn;
  end

  // R9: acknowledge only directly after the wipe cycle
  p_ack_follows_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.setAck |-> $past(strb.clearAll));
endmodule

// File: rtl/err_bound_dp.sv
module err_bound_dp
  import err_bound_pkg::*;
#(
  parameter int unsigned ERR_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              sampleValid,
  input  logic [ERR_W-1:0]  sampleErr,
  input  logic              accumDone,
  input  logic              avgValid,
  input  logic              avgErrOk,
  input  logic              minMaxOk,
  input  logic              errGenOk,
  input  ctlStrobe_t        strb,
  output logic              modEn,
  output logic              cpuIrq,
  output logic              vpIrq
);
  localparam int unsigned EN_W = NUM_SRC + 1;
  localparam logic [ERR_W-1:0] MAX_RST = {1'b0, {(ERR_W-1){1'b1}}};
  localparam logic [ERR_W-1:0] MIN_RST = {1'b1, {(ERR_W-1){1'b0}}};

  logic               enQ;
  logic [ERR_W-1:0]   maxLim;
  logic [ERR_W-1:0]   minLim;
  logic [EN_W-1:0]    irqEn;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] clrVec;
  logic               boundsHit;

  err_bound_cmp #(.ERR_W(ERR_W)) u_cmp (
    .valid (sampleValid),
    .gate  (strb.evtGate),
    .sample(sampleErr),
    .maxLim(maxLim),
    .minLim(minLim),
    .hit   (boundsHit)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      maxLim <= MAX_RST;
      minLim <= MIN_RST;
      irqEn  <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADR_CTRL:  enQ <= regWrData[0];
        ADR_LIMIT: begin
          maxLim <= regWrData[2*ERR_W-1:ERR_W];
          minLim <= regWrData[ERR_W-1:0];
        end
        ADR_IEN:   irqEn <= regWrData[EN_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    setVec             = '0;
    setVec[SRC_ACC]    = accumDone && strb.evtGate;
    setVec[SRC_VALID]  = avgValid && strb.evtGate;
    setVec[SRC_DISACK] = strb.setAck;
    setVec[SRC_BOUNDS] = boundsHit;
    clrVec = (regWrEn && regAddr == ADR_PEND) ? regWrData[NUM_SRC-1:0] : '0;
  end

  // one pending cell per source; a set beats a write-1 clear
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_pend
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              pend[gi] <= 1'b0;
      else if (strb.clearAll) pend[gi] <= 1'b0;
      else if (setVec[gi])    pend[gi] <= 1'b1;
      else if (clrVec[gi])    pend[gi] <= 1'b0;
    end
  end

  always_comb begin
    cpuIrq = |(pend & irqEn[NUM_SRC-1:0]);
    vpIrq  = pend[SRC_BOUNDS] && irqEn[VP_EN_BIT];
    modEn  = enQ;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADR_CTRL:  regRdData[0] = enQ;
      ADR_LIMIT: regRdData[2*ERR_W-1:0] = {maxLim, minLim};
      ADR_IEN:   regRdData[EN_W-1:0] = irqEn;
      ADR_PEND:  regRdData[NUM_SRC-1:0] = pend;
      ADR_STATUS: begin
        regRdData[3] = avgErrOk;
        regRdData[2] = minMaxOk;
        regRdData[1] = errGenOk;
      end
      default: ;
    endcase
  end

  // R2: a comparator hit always lands in the bounds pending bit
  p_bounds_pend_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(boundsHit) |-> pend[SRC_BOUNDS]);

  // R6: set beats a simultaneous write-1 clear
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(setVec[SRC_ACC] && clrVec[SRC_ACC] && !strb.clearAll) |-> pend[SRC_ACC]);

  // R9: the wipe leaves nothing pending
  p_wipe_all_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.clearAll) |-> (pend == '0));

  // R3: no bounds pending can appear while gated off
  p_quiet_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.evtGate) |-> !$rose(pend[SRC_BOUNDS]));
endmodule

// File: rtl/err_bound_irq.sv
module err_bound_irq
  import err_bound_pkg::*;
#(
  parameter int unsigned ERR_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              sampleValid,
  input  logic [ERR_W-1:0]  sampleErr,
  input  logic              accumDone,
  input  logic              avgValid,
  input  logic              avgErrOk,
  input  logic              minMaxOk,
  input  logic              errGenOk,
  output logic              cpuIrq,
  output logic              vpIrq
);
  ctlStrobe_t strb;
  logic       modEn;

  err_bound_ctl u_ctl (
    .clk  (clk),
    .rstN (rstN),
    .modEn(modEn),
    .strb (strb)
  );

  err_bound_dp #(.ERR_W(ERR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .sampleValid(sampleValid),
    .sampleErr  (sampleErr),
    .accumDone  (accumDone),
    .avgValid   (avgValid),
    .avgErrOk   (avgErrOk),
    .minMaxOk   (minMaxOk),
    .errGenOk   (errGenOk),
    .strb       (strb),
    .modEn      (modEn),
    .cpuIrq     (cpuIrq),
    .vpIrq      (vpIrq)
  );
endmodule

// File: tb/err_bound_irq_bench.sv
module err_bound_irq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sampleValid = 1'b0;
  logic [7:0]  sampleErr = '0;
  logic        accumDone = 1'b0;
  logic        avgValid = 1'b0;
  logic        avgErrOk = 1'b0;
  logic        minMaxOk = 1'b0;
  logic        errGenOk = 1'b0;
  logic        cpuIrq;
  logic        vpIrq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  err_bound_irq u_err_bound_irq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sampleValid(sampleValid),
    .sampleErr(sampleErr), .accumDone(accumDone), .avgValid(avgValid),
    .avgErrOk(avgErrOk), .minMaxOk(minMaxOk), .errGenOk(errGenOk),
    .cpuIrq(cpuIrq), .vpIrq(vpIrq)
  );

  // {max, min, sample, expected hit}
  localparam logic [24:0] VEC [9] = '{
    {8'h0A, 8'hF6, 8'h0A, 1'b0},
    {8'h0A, 8'hF6, 8'h0B, 1'b1},
    {8'h0A, 8'hF6, 8'hF6, 1'b0},
    {8'h0A, 8'hF6, 8'hF5, 1'b1},
    {8'h7F, 8'h80, 8'h7F, 1'b0},
    {8'h7F, 8'h80, 8'h80, 1'b0},
    {8'hFB, 8'hEC, 8'h00, 1'b1},
    {8'hFB, 8'hEC, 8'hFA, 1'b0},
    {8'hFB, 8'hEC, 8'hEC, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic sample(input logic v, input logic [7:0] s);
    @(negedge clk);
    sampleValid = v; sampleErr = s;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic events(input logic a, input logic v);
    @(negedge clk);
    accumDone = a; avgValid = v;
    @(negedge clk);
    accumDone = 1'b0; avgValid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd3, d); chk("R1 pending", d, 32'h0);
    rd(3'd2, d); chk("R1 enables", d, 32'h0);
    rd(3'd1, d); chk("R1 limits", d, 32'h7F80);
    rd(3'd0, d); chk("R1 ctrl", d, 32'h0);
    chk("R1 irqs", {30'b0, cpuIrq, vpIrq}, 32'h0);

    wr(3'd0, 32'h1);

    // R2 / R11 table
    foreach (VEC[i]) begin
      wr(3'd1, {16'h0, VEC[i][24:17], VEC[i][16:9]});
      rd(3'd1, d); chk("R11 limit readback", d, {16'h0, VEC[i][24:17], VEC[i][16:9]});
      wr(3'd3, 32'hF);
      sample(1'b1, VEC[i][8:1]);
      rd(3'd3, d); chk("R2 bounds compare", {31'b0, d[3]}, {31'b0, VEC[i][0]});
    end

    // R3 sampleValid low
    wr(3'd1, 32'h0A_F6);
    wr(3'd3, 32'hF);
    sample(1'b0, 8'h64);
    rd(3'd3, d); chk("R3 unqualified sample", d, 32'h0);

    // R4 events, enables all zero; R7 no interrupt
    events(1'b1, 1'b0);
    rd(3'd3, d); chk("R4 accum sets bit0", d, 32'h1);
    events(1'b0, 1'b1);
    rd(3'd3, d); chk("R4 valid sets bit1", d, 32'h3);
    chk("R7 masked cpuIrq", {31'b0, cpuIrq}, 32'h0);

    // R5 write-1 clear
    wr(3'd3, 32'h1);
    rd(3'd3, d); chk("R5 selective clear", d, 32'h2);

    // R7 enable mapping
    wr(3'd2, 32'h2);
    chk("R7 enabled cpuIrq", {31'b0, cpuIrq}, 32'h1);
    wr(3'd2, 32'h1);
    chk("R7 other enable", {31'b0, cpuIrq}, 32'h0);

    // R6 set wins
    @(negedge clk);
    accumDone = 1'b1; regWrEn = 1'b1; regAddr = 3'd3; regWrData = 32'h1;
    @(negedge clk);
    accumDone = 1'b0; regWrEn = 1'b0;
    rd(3'd3, d); chk("R6 set beats clear", d, 32'h3);

    // R8 voltage-processor line
    wr(3'd3, 32'hF);
    wr(3'd2, 32'h10);
    sample(1'b1, 8'h20);
    chk("R8 vp only", {30'b0, cpuIrq, vpIrq}, 32'h1);
    wr(3'd2, 32'h08);
    chk("R8 cpu only", {30'b0, cpuIrq, vpIrq}, 32'h2);

    // R10 status
    avgErrOk = 1'b1; minMaxOk = 1'b0; errGenOk = 1'b1;
    rd(3'd4, d); chk("R10 status a", d, 32'hA);
    avgErrOk = 1'b0; minMaxOk = 1'b1; errGenOk = 1'b0;
    rd(3'd4, d); chk("R10 status b", d, 32'h4);

    // R9 disable sequence
    events(1'b1, 1'b0);
    rd(3'd3, d); chk("R9 pre-disable", d, 32'h9);
    wr(3'd2, 32'h4);
    wr(3'd0, 32'h0);
    rd(3'd3, d); chk("R9 before wipe", d, 32'h9);
    @(negedge clk);
    rd(3'd3, d); chk("R9 wiped", d, 32'h0);
    @(negedge clk);
    rd(3'd3, d); chk("R9 ack set", d, 32'h4);
    chk("R9 ack irq", {31'b0, cpuIrq}, 32'h1);

    // R3 disabled: nothing new latches
    sample(1'b1, 8'h7F);
    events(1'b1, 1'b1);
    rd(3'd3, d); chk("R3 disabled ignores", d, 32'h4);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule